// File: doc/BRIEF.md
# Four-Function-Pair Bit-Slice ALU

This block is a combinational arithmetic/logic unit assembled from identical one-bit cells joined by a ripple carry. A mode input chooses between a logic group, where every bit position computes its output from the two operand bits at that position alone, and an arithmetic group, where the cells form a sum that ripples from the least significant cell upward. Two select bits and a carry input pick one of the operations in the active group.

In arithmetic mode, select bit 0 inverts operand A before it enters the adder and select bit 1 lets operand B in. The carry input supplies the +1 term. The resulting set includes pass, complement, increment, two's-complement negation, add, add-with-carry and B minus A. The operand width is a parameter (default 4). Several instances can be cascaded for wider words by feeding one instance's carry output into the next instance's carry input, with all control pins shared.

The block has no clock and no handshake. The result settles after a ripple delay through all cells.

Top module: `alu_slice_array`

## Requirements
- R1: With `arith_mode`=0, each result bit depends only on the operand bits at the same position: `op_sel` 0 gives A, 1 gives NOT A, 2 gives A XOR B, 3 gives A XNOR B (`op_sel` bit 1 is the MSB of the code).
- R2: With `arith_mode`=1 and `carry_in`=0, `op_sel` 0 gives A, 1 gives NOT A, 2 gives A plus B, and 3 gives (NOT A) plus B, all modulo 2^WIDTH.
- R3: With `arith_mode`=1 and `carry_in`=1, `op_sel` 0 gives A plus 1, 1 gives (NOT A) plus 1, 2 gives A plus B plus 1, and 3 gives (NOT A) plus B plus 1, all modulo 2^WIDTH.
- R4: When `op_sel` bit 1 is 0, operand B has no effect on `result` or `carry_out` in either mode.
- R5: With `arith_mode`=0, `carry_in` has no effect on `result`.
- R6: With `arith_mode`=0, `carry_out` is 0 for every operand and select value.
- R7: With `arith_mode`=1, `carry_out` equals bit WIDTH of the full-width sum of (A, inverted when `op_sel` bit 0 is 1), (B when `op_sel` bit 1 is 1, else 0) and `carry_in`.
- R8: The B-minus-A operation (`arith_mode`=1, `op_sel`=3, `carry_in`=1) gives the two's-complement difference. Its `carry_out` is 1 exactly when B >= A. The negate operation (`op_sel`=1, `carry_in`=1) produces `carry_out`=1 only for A=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arith_mode | input | 1 | 0 selects the logic group, 1 selects the arithmetic group |
| op_sel | input | 2 | Operation select within the group; bit 0 inverts A, bit 1 admits B |
| carry_in | input | 1 | Carry into the least significant cell (arithmetic mode only) |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the most significant cell; 0 in logic mode |

## Verification
The bench targets the cases where a wrong carry gate shows up at the ports. If the carry input leaked into logic mode, XOR would turn into XNOR on bit 0 or the carry output would be raised. If B were not blocked, pass and complement would add B in. Negating zero and subtracting equal operands both require a carry that ripples through every cell; a design with a broken chain link would clear the carry or flip an upper bit. Every operand, select and carry combination is also swept against an independent model, so a swapped select decode or an inverted A in the wrong code would fail there.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // Select code; bit 0 inverts A, bit 1 admits B.
  typedef enum logic [1:0] {
    SEL_PASS_A = 2'b00,
    SEL_NOT_A  = 2'b01,
    SEL_WITH_B = 2'b10,
    SEL_NOTA_B = 2'b11
  } alu_sel_e;

  // Gating controls shared by every cell.
  typedef struct packed {
    logic a_invert;
    logic b_admit;
    logic carry_admit;
  } cell_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_slice_pkg::*;
(
  input  logic       arith_mode,
  input  logic [1:0] op_sel,
  output cell_ctrl_t ctrl
);

  alu_sel_e sel_code;

  always_comb begin
    sel_code         = alu_sel_e'(op_sel);
    ctrl.a_invert    = (sel_code == SEL_NOT_A)  || (sel_code == SEL_NOTA_B);
    ctrl.b_admit     = (sel_code == SEL_WITH_B) || (sel_code == SEL_NOTA_B);
    ctrl.carry_admit = arith_mode;
  end

  always_comb begin
    if (!op_sel[1]) assert (!ctrl.b_admit) else $error("AST_B_BLOCKED"); // R4
    if (!arith_mode) assert (!ctrl.carry_admit) else $error("AST_CARRY_BLOCKED"); // R5
  end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_slice_pkg::*;
(
  input  cell_ctrl_t ctrl,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       c_in,
  output logic       f_bit,
  output logic       c_out
);

  logic a_eff, b_eff, c_eff, half_sum;

  always_comb begin
    a_eff    = a_bit ^ ctrl.a_invert;
    b_eff    = b_bit & ctrl.b_admit;
    c_eff    = c_in & ctrl.carry_admit;
    half_sum = a_eff ^ b_eff;
    f_bit    = half_sum ^ c_eff;
    c_out    = ctrl.carry_admit & ((a_eff & b_eff) | (c_eff & half_sum));
  end

  always_comb begin
    if (!ctrl.carry_admit)
      assert (f_bit == ((a_bit ^ ctrl.a_invert) ^ (b_bit & ctrl.b_admit)))
        else $error("AST_CELL_IGNORES_CIN"); // R5
  end

endmodule

// File: rtl/alu_slice_array.sv
module alu_slice_array
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             arith_mode,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int CHAIN_LEN = WIDTH + 1;

  cell_ctrl_t           ctrl;
  logic [CHAIN_LEN-1:0] chain;

  alu_op_decode u_decode (
    .arith_mode (arith_mode),
    .op_sel     (op_sel),
    .ctrl       (ctrl)
  );

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_bit_cell u_cell (
      .ctrl  (ctrl),
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .c_in  (chain[i]),
      .f_bit (result[i]),
      .c_out (chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH];

  // Reference sum built with a wide adder, independent of the cell chain.
  logic [WIDTH:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, opa ^ {WIDTH{op_sel[0]}}}
            + {1'b0, opb & {WIDTH{op_sel[1]}}}
            + {{WIDTH{1'b0}}, carry_in};
  end

  always_comb begin
    if (!arith_mode) begin
      assert (carry_out == 1'b0) else $error("AST_LOGIC_NO_CARRY"); // R6
      assert (result == ((opa ^ {WIDTH{op_sel[0]}}) ^ (opb & {WIDTH{op_sel[1]}})))
        else $error("AST_LOGIC_BITWISE"); // R1
    end else begin
      assert (result == ref_sum[WIDTH-1:0]) else $error("AST_ARITH_SUM"); // R2 R3
      assert (carry_out == ref_sum[WIDTH]) else $error("AST_ARITH_CARRY"); // R7
    end
  end

endmodule

// File: tb/alu_slice_array_tb.sv
module alu_slice_array_tb;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic         arith_mode;
  logic [1:0]   op_sel;
  logic         carry_in;
  logic [W-1:0] opa, opb;
  logic [W-1:0] result;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  alu_slice_array #(.WIDTH(W)) u_dut (
    .arith_mode (arith_mode),
    .op_sel     (op_sel),
    .carry_in   (carry_in),
    .opa        (opa),
    .opb        (opb),
    .result     (result),
    .carry_out  (carry_out)
  );

  // Vector: {mode, sel[1:0], cin, a[3:0], b[3:0], f[3:0], cout}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 4'h5, 4'h3, 4'h5, 1'b0}, // R1 pass
    {1'b0, 2'd1, 1'b1, 4'h5, 4'h3, 4'hA, 1'b0}, // R1 R5 not
    {1'b0, 2'd2, 1'b0, 4'hC, 4'hA, 4'h6, 1'b0}, // R1 xor
    {1'b0, 2'd3, 1'b1, 4'hC, 4'hA, 4'h9, 1'b0}, // R1 R5 xnor
    {1'b1, 2'd0, 1'b0, 4'h7, 4'hF, 4'h7, 1'b0}, // R2 R4
    {1'b1, 2'd2, 1'b0, 4'h9, 4'h8, 4'h1, 1'b1}, // R2 R7
    {1'b1, 2'd3, 1'b0, 4'h3, 4'h5, 4'h1, 1'b1}, // R2
    {1'b1, 2'd0, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1}, // R3 full ripple
    {1'b1, 2'd1, 1'b1, 4'h0, 4'h9, 4'h0, 1'b1}, // R8 negate zero
    {1'b1, 2'd1, 1'b1, 4'h3, 4'h0, 4'hD, 1'b0}, // R8 negate
    {1'b1, 2'd3, 1'b1, 4'h5, 4'h3, 4'hE, 1'b0}, // R8 borrow
    {1'b1, 2'd3, 1'b1, 4'h3, 4'h5, 4'h2, 1'b1}, // R8 no borrow
    {1'b1, 2'd2, 1'b1, 4'hF, 4'hF, 4'hF, 1'b1}, // R3
    {1'b1, 2'd1, 1'b0, 4'h6, 4'hF, 4'h9, 1'b0}  // R4
  };

  task automatic apply(input logic m, input logic [1:0] s, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    arith_mode = m; op_sel = s; carry_in = c; opa = a; opb = b;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] ef, input logic ec);
    total++;
    if (result !== ef || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: m=%0b s=%0d c=%0b a=%h b=%h got f=%h co=%0b expected f=%h co=%0b",
               req, arith_mode, op_sel, carry_in, opa, opb, result, carry_out, ef, ec);
    end
  endtask

  function automatic logic [W:0] model(input logic m, input logic [1:0] s, input logic c,
                                       input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] ax, bx;
    logic [W:0]   sum;
    ax = s[0] ? ~a : a;
    bx = s[1] ? b : '0;
    if (!m) return {1'b0, s[1] ? (ax ^ bx) : ax};
    sum = {1'b0, ax} + {1'b0, bx} + {{W{1'b0}}, c};
    return sum;
  endfunction

  initial begin
    arith_mode = 1'b0; op_sel = 2'd0; carry_in = 1'b0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: all-zero inputs, logic pass.
    apply(1'b0, 2'd0, 1'b0, 4'h0, 4'h0);
    check("R1 idle", 4'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][16], VEC[i][15:14], VEC[i][13], VEC[i][12:9], VEC[i][8:5]);
      check("R1-table", VEC[i][4:1], VEC[i][0]);
    end

    // Exhaustive sweep: R1 R2 R3 R6 R7.
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int cc = 0; cc < 2; cc++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            logic [W:0] exp_v;
            exp_v = model(ctl[2], ctl[1:0], cc[0], a[3:0], b[3:0]);
            apply(ctl[2], ctl[1:0], cc[0], a[3:0], b[3:0]);
            check(ctl[2] ? (cc[0] ? "R3 R7 sweep" : "R2 R7 sweep") : "R1 R6 sweep",
                  exp_v[W-1:0], exp_v[W]);
          end
        end
      end
    end

    // R4: B sweep has no effect when select bit 1 is 0.
    for (int b = 0; b < 16; b++) begin
      apply(1'b1, 2'd1, 1'b1, 4'h4, b[3:0]);
      check("R4 b ignored", 4'hC, 1'b0);
    end

    // R5: carry_in toggled in logic xor leaves result unchanged; R6 carry stays 0.
    apply(1'b0, 2'd2, 1'b1, 4'hF, 4'h0);
    check("R5 cin ignored", 4'hF, 1'b0);
    apply(1'b0, 2'd3, 1'b1, 4'hF, 4'hF);
    check("R6 logic carry", 4'hF, 1'b0);

    // R8: B minus A with equal operands gives 0 and carry 1.
    apply(1'b1, 2'd3, 1'b1, 4'h9, 4'h9);
    check("R8 equal", 4'h0, 1'b1);
    apply(1'b1, 2'd3, 1'b1, 4'hF, 4'h0);
    check("R8 max borrow", 4'h1, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule